// File: doc/BRIEF.md
# Split-Mode 64/32-Bit Interval Timer

This block is a register-programmed interval timer. Its count state is two 32-bit words that either form one 64-bit up-counter or run as two fully independent 32-bit up-counters, the lower half and the upper half. Each half has its own count register, period register and 2-bit run-mode field, and can be disabled, fired once or made to repeat. When a running count reaches its period, the timer pulses an interrupt line. The lower half also offers a bank of eight compare registers. Any of them raises a separate compare interrupt when the lower count equals it.

Software sets the timer up over a simple synchronous register bus. It picks the counter arrangement and releases each half from its held state through a setup register. It then loads counts, periods and compare values, and finally starts a half by writing its run-mode field. A common use pairs a free-running lower half with compare values. Software computes each compare value as the current count plus a delay, wrapping modulo 2^32.

Top module: `split_timer`

## Requirements
- R1: After `rst_n` is low, every register reads 0, and `irq_lo`, `irq_hi` and `irq_cmp` are low.
- R2: The register map uses word addresses. Address 0 is the lower count, 1 the upper count, 2 the lower period, 3 the upper period, 4 run control, 5 setup, and 8+i compare register i for i = 0..7. Addresses 6 and 7 read 0. Run control reads back only its two run-mode fields and setup reads back only bits 3:0.
- R3: Setup bit 0 releases the lower half and bit 1 releases the upper half. While its bit is 0, a half keeps its count at 0, ignores writes to its count, ignores its run-mode field and raises no interrupt.
- R4: The run-mode field of the lower half is run-control bits 7:6 and that of the upper half is bits 23:22. Code 0 is off, 1 is one-shot, 2 is repeating and 3 behaves as off. The two halves run independently.
- R5: In split mode (setup bits 3:2 = 1), a released half whose field is 1 or 2 adds 1 to its count every cycle. A bus write to a count register loads the written value, and the load wins over counting.
- R6: Repeating mode: in the cycle when a running count equals its period, the count becomes 0 at the next edge, and the half's interrupt is high for exactly the one following cycle. With period P, the interrupt therefore recurs every P+1 cycles.
- R7: One-shot mode: when the count equals the period, the half's interrupt pulses once, the count stays at the period value and the run-mode field reads back 0.
- R8: A count above its period counts on to 2^32-1 and wraps to 0 with no interrupt, then continues up to the period.
- R9: In wide mode (setup bits 3:2 = 0), both release bits must be set. The lower run-mode field then drives one 64-bit counter {upper, lower}, which carries from the lower word into the upper word. It matches against {upper period, lower period} and signals on `irq_lo`. The upper field and `irq_hi` are unused in this mode.
- R10: Setup bits 3:2 = 2 or 3 stop both counters, and neither half interrupt is raised.
- R11: While the lower count is running in either mode, `irq_cmp` is high in the cycle after any cycle in which the lower count equals any compare register. Matching uses the plain 32-bit count, so compare values formed by wrapping addition are reached after the counter wraps. When the lower count is not running, `irq_cmp` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW (4) | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from the address |
| irq_lo | output | 1 | Lower-half (or wide-mode) period interrupt |
| irq_hi | output | 1 | Upper-half period interrupt |
| irq_cmp | output | 1 | Compare-match interrupt for the lower half |

## Verification
A register write takes effect at the clock edge that captures it. A running count therefore shows its first increment one edge after the enabling write. The period and compare interrupts are registered and appear one cycle after the cycle in which the count equals the period or compare value. The bench performs every write on a falling-edge-to-falling-edge window and indexes the following falling edges as j = 0, 1, 2 and so on. At each index it computes the expected count and interrupt level arithmetically, for example j mod (P+1) and a pulse when j is a nonzero multiple of P+1. It then compares these with the read port and interrupt pins, sampled just after that falling edge.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

  typedef enum logic [1:0] {
    RUN_OFF  = 2'd0,
    RUN_ONCE = 2'd1,
    RUN_LOOP = 2'd2,
    RUN_RSV  = 2'd3
  } run_mode_e;

  typedef enum logic [1:0] {
    ARR_WIDE  = 2'd0,
    ARR_SPLIT = 2'd1,
    ARR_WDOG  = 2'd2,
    ARR_CHAIN = 2'd3
  } arrange_e;

  localparam int ADR_CNT_LO = 0;
  localparam int ADR_CNT_HI = 1;
  localparam int ADR_PRD_LO = 2;
  localparam int ADR_PRD_HI = 3;
  localparam int ADR_RUN    = 4;
  localparam int ADR_SETUP  = 5;

  localparam int RUN_LO_POS = 6;
  localparam int RUN_HI_POS = 22;

  function automatic logic runs(input run_mode_e m);
    return (m == RUN_ONCE) || (m == RUN_LOOP);
  endfunction

  function automatic logic all_ones(input logic [31:0] v);
    return &v;
  endfunction

endpackage

// File: rtl/tmr_half.sv
module tmr_half #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  input  logic         restart,
  output logic [W-1:0] cnt
);

  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (hold)    cnt <= '0;
    else if (ld)      cnt <= ld_val;
    else if (restart) cnt <= '0;
    else if (step)    cnt <= bump(cnt);
  end

endmodule

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank #(
  parameter int W  = 32,
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_val,
  input  logic          arm,
  input  logic [W-1:0]  cnt,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_val,
  output logic          hit_any
);

  logic [W-1:0] slot [N];
  logic [N-1:0] eq;

  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (!rst_n)                           slot[k] <= '0;
      else if (wr && (wr_idx == IW'(k)))    slot[k] <= wr_val;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_eq
    assign eq[g] = arm && (slot[g] == cnt);
  end

  assign rd_val  = slot[rd_idx];
  assign hit_any = |eq;

endmodule

// File: rtl/split_timer.sv
module split_timer
  import split_timer_pkg::*;
#(
  parameter int AW   = 4,
  parameter int NCMP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq_lo,
  output logic          irq_hi,
  output logic          irq_cmp
);

  localparam int W  = 32;
  localparam int IW = (NCMP > 1) ? $clog2(NCMP) : 1;

  logic [W-1:0] cnt_lo, cnt_hi, prd_lo, prd_hi, cmp_rd;
  run_mode_e    em_lo, em_hi;
  arrange_e     arr;
  logic         rel_lo, rel_hi;

  logic wr_cnt_lo, wr_cnt_hi, wr_prd_lo, wr_prd_hi, wr_ctrl, wr_setup;
  logic cmp_sel, wr_cmp;
  assign wr_cnt_lo = bus_we && (bus_addr == AW'(ADR_CNT_LO));
  assign wr_cnt_hi = bus_we && (bus_addr == AW'(ADR_CNT_HI));
  assign wr_prd_lo = bus_we && (bus_addr == AW'(ADR_PRD_LO));
  assign wr_prd_hi = bus_we && (bus_addr == AW'(ADR_PRD_HI));
  assign wr_ctrl   = bus_we && (bus_addr == AW'(ADR_RUN));
  assign wr_setup  = bus_we && (bus_addr == AW'(ADR_SETUP));
  assign cmp_sel   = bus_addr[AW-1] && (int'(bus_addr[AW-2:0]) < NCMP);
  assign wr_cmp    = bus_we && cmp_sel;

  // Named internal events
  logic split_m, wide_m, act_lo, act_hi, act_w;
  logic hit_lo, hit_hi, hit_w, lo_evt, hi_evt;
  logic step_lo, step_hi, rs_lo, rs_hi, done_lo, done_hi, cmp_any;

  assign split_m = (arr == ARR_SPLIT);
  assign wide_m  = (arr == ARR_WIDE);
  assign act_lo  = split_m && rel_lo && runs(em_lo);
  assign act_hi  = split_m && rel_hi && runs(em_hi);
  assign act_w   = wide_m && rel_lo && rel_hi && runs(em_lo);
  assign hit_lo  = act_lo && (cnt_lo == prd_lo);
  assign hit_hi  = act_hi && (cnt_hi == prd_hi);
  assign hit_w   = act_w && ({cnt_hi, cnt_lo} == {prd_hi, prd_lo});
  assign lo_evt  = hit_lo || hit_w;
  assign hi_evt  = hit_hi;
  assign step_lo = (act_lo && !hit_lo) || (act_w && !hit_w);
  assign step_hi = (act_hi && !hit_hi) || (act_w && !hit_w && all_ones(cnt_lo));
  assign rs_lo   = lo_evt && (em_lo == RUN_LOOP);
  assign rs_hi   = (hit_hi && (em_hi == RUN_LOOP)) || (hit_w && (em_lo == RUN_LOOP));
  assign done_lo = lo_evt && (em_lo == RUN_ONCE);
  assign done_hi = hit_hi && (em_hi == RUN_ONCE);

  tmr_half #(.W(W)) u_lo (
    .clk(clk), .rst_n(rst_n), .hold(!rel_lo), .ld(wr_cnt_lo), .ld_val(bus_wdata),
    .step(step_lo), .restart(rs_lo), .cnt(cnt_lo)
  );

  tmr_half #(.W(W)) u_hi (
    .clk(clk), .rst_n(rst_n), .hold(!rel_hi), .ld(wr_cnt_hi), .ld_val(bus_wdata),
    .step(step_hi), .restart(rs_hi), .cnt(cnt_hi)
  );

  tmr_cmp_bank #(.W(W), .N(NCMP), .IW(IW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr(wr_cmp), .wr_idx(bus_addr[IW-1:0]),
    .wr_val(bus_wdata), .arm(act_lo || act_w), .cnt(cnt_lo),
    .rd_idx(bus_addr[IW-1:0]), .rd_val(cmp_rd), .hit_any(cmp_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_lo  <= '0;
      prd_hi  <= '0;
      em_lo   <= RUN_OFF;
      em_hi   <= RUN_OFF;
      arr     <= ARR_WIDE;
      rel_lo  <= 1'b0;
      rel_hi  <= 1'b0;
      irq_lo  <= 1'b0;
      irq_hi  <= 1'b0;
      irq_cmp <= 1'b0;
    end else begin
      if (wr_prd_lo) prd_lo <= bus_wdata;
      if (wr_prd_hi) prd_hi <= bus_wdata;
      if (wr_ctrl) begin
        em_lo <= run_mode_e'(bus_wdata[RUN_LO_POS +: 2]);
        em_hi <= run_mode_e'(bus_wdata[RUN_HI_POS +: 2]);
      end else begin
        if (done_lo) em_lo <= RUN_OFF;
        if (done_hi) em_hi <= RUN_OFF;
      end
      if (wr_setup) begin
        arr    <= arrange_e'(bus_wdata[3:2]);
        rel_hi <= bus_wdata[1];
        rel_lo <= bus_wdata[0];
      end
      irq_lo  <= lo_evt;
      irq_hi  <= hi_evt;
      irq_cmp <= cmp_any;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (cmp_sel) begin
      bus_rdata = cmp_rd;
    end else begin
      case (bus_addr)
        AW'(ADR_CNT_LO): bus_rdata = cnt_lo;
        AW'(ADR_CNT_HI): bus_rdata = cnt_hi;
        AW'(ADR_PRD_LO): bus_rdata = prd_lo;
        AW'(ADR_PRD_HI): bus_rdata = prd_hi;
        AW'(ADR_RUN): begin
          bus_rdata[RUN_LO_POS +: 2] = em_lo;
          bus_rdata[RUN_HI_POS +: 2] = em_hi;
        end
        AW'(ADR_SETUP): bus_rdata[3:0] = {arr, rel_hi, rel_lo};
        default: bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/split_timer_chk.sv
module split_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  arr,
  input logic        rel_lo,
  input logic [1:0]  em_lo,
  input logic [31:0] cnt_lo,
  input logic [31:0] cnt_hi,
  input logic        act_lo,
  input logic        act_w,
  input logic        hit_lo,
  input logic        hit_w,
  input logic        wr_cnt_lo,
  input logic        wr_cnt_hi,
  input logic        wr_ctrl,
  input logic        irq_lo,
  input logic        irq_hi,
  input logic        irq_cmp
);

  // R3
  held_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_lo |=> (cnt_lo == 32'd0));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_lo && !hit_lo && !wr_cnt_lo) |=> (cnt_lo == $past(cnt_lo) + 32'd1));

  // R6
  loop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lo && (em_lo == 2'd2) && !wr_cnt_lo) |=> ((cnt_lo == 32'd0) && irq_lo));

  // R7
  once_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_lo || hit_w) && (em_lo == 2'd1) && !wr_ctrl) |=> ((em_lo == 2'd0) && irq_lo));

  // R9
  wide_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_w && !hit_w && (&cnt_lo) && !wr_cnt_lo && !wr_cnt_hi)
      |=> ((cnt_lo == 32'd0) && (cnt_hi == $past(cnt_hi) + 32'd1)));

  // R10
  parked_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr[1] && rel_lo && !wr_cnt_lo) |=> $stable(cnt_lo));

  // R10
  parked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr[1] |=> (!irq_lo && !irq_hi));

  // R11
  cmp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_lo && !act_w) |=> !irq_cmp);

endmodule

bind split_timer split_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arr(arr), .rel_lo(rel_lo), .em_lo(em_lo),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .act_lo(act_lo), .act_w(act_w),
  .hit_lo(hit_lo), .hit_w(hit_w), .wr_cnt_lo(wr_cnt_lo), .wr_cnt_hi(wr_cnt_hi),
  .wr_ctrl(wr_ctrl), .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_cmp(irq_cmp)
);

// File: tb/split_timer_test.sv
module split_timer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq_lo, irq_hi, irq_cmp;
  int          n_vec = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  split_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_cmp(irq_cmp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 4'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 4'(a);
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, lo, hi, st;
    logic [63:0] w;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 16; a++) begin
      rd(a, v);
      check("R1 reg", v, 32'h0);
    end
    check("R1 irq", {29'd0, irq_lo, irq_hi, irq_cmp}, 32'h0);

    // R2: map and readback, parked arrangement so nothing runs
    wr(5, 32'hFFFF_FFF8);
    wr(2, 32'h1234_5678);
    wr(3, 32'h9ABC_DEF0);
    wr(4, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) wr(8 + i, 32'h1111_1111 * i + 32'd1);
    rd(2, v); check("R2 prd_lo", v, 32'h1234_5678);
    rd(3, v); check("R2 prd_hi", v, 32'h9ABC_DEF0);
    rd(4, v); check("R2 run", v, 32'h00C0_00C0);
    rd(5, v); check("R2 setup", v, 32'h8);
    rd(6, v); check("R2 hole6", v, 32'h0);
    rd(7, v); check("R2 hole7", v, 32'h0);
    for (int i = 0; i < 8; i++) begin
      rd(8 + i, v);
      check("R2 cmp", v, 32'h1111_1111 * i + 32'd1);
    end
    wr(4, 0);

    // R3: held halves
    wr(5, 32'h4);
    wr(0, 55);
    rd(0, v); check("R3 held write", v, 32'h0);
    wr(2, 0);
    wr(4, 2 << 6);
    for (int j = 0; j < 4; j++) begin
      rd(0, v); check("R3 held cnt", v, 32'h0);
      check("R3 held irq", {31'd0, irq_lo}, 32'h0);
      @(negedge clk);
    end
    wr(5, 32'h5);
    for (int j = 0; j < 4; j++) begin
      check("R3 released irq", {31'd0, irq_lo}, (j > 0) ? 32'd1 : 32'd0);
      @(negedge clk);
    end

    // R5 R6: repeating sweep on the lower half
    wr(5, 32'h7);
    for (int p = 0; p < 6; p++) begin
      wr(4, 0); wr(0, 0); wr(2, p); wr(4, 2 << 6);
      for (int j = 0; j < 3 * (p + 1) + 2; j++) begin
        rd(0, v);
        check("R6 loop cnt", v, 32'(j % (p + 1)));
        check("R6 loop irq", {31'd0, irq_lo}, ((j > 0) && (j % (p + 1) == 0)) ? 32'd1 : 32'd0);
        check("R4 hi quiet", {31'd0, irq_hi}, 32'd0);
        @(negedge clk);
      end
    end

    // R7: one-shot sweep
    for (int p = 0; p < 5; p++) begin
      wr(4, 0); wr(0, 0); wr(2, p); wr(4, 1 << 6);
      for (int j = 0; j < p + 5; j++) begin
        rd(0, v);
        check("R7 once cnt", v, 32'((j < p) ? j : p));
        check("R7 once irq", {31'd0, irq_lo}, (j == p + 1) ? 32'd1 : 32'd0);
        @(negedge clk);
      end
      rd(4, v); check("R7 field cleared", v, 32'h0);
    end

    // R4: code 3 behaves as off; R5: load wins
    wr(0, 9);
    wr(4, 3 << 6);
    for (int j = 0; j < 3; j++) begin
      rd(0, v); check("R4 code3 cnt", v, 32'd9);
      check("R4 code3 irq", {31'd0, irq_lo}, 32'd0);
      @(negedge clk);
    end

    // R8: count above period wraps without interrupt
    st = 32'hFFFF_FFFD;
    wr(4, 0); wr(0, st); wr(2, 5); wr(4, 2 << 6);
    for (int j = 0; j < 10; j++) begin
      rd(0, v);
      if (j <= 8) check("R8 wrap cnt", v, st + 32'(j));
      check("R8 wrap irq", {31'd0, irq_lo}, (j == 9) ? 32'd1 : 32'd0);
      @(negedge clk);
    end

    // R4: both halves, independent periods
    wr(4, 0); wr(0, 0); wr(1, 0); wr(2, 2); wr(3, 4);
    wr(4, (2 << 22) | (2 << 6));
    for (int j = 0; j < 21; j++) begin
      rd(0, lo); rd(1, hi);
      check("R4 pair lo", lo, 32'(j % 3));
      check("R4 pair hi", hi, 32'(j % 5));
      check("R4 pair irq_lo", {31'd0, irq_lo}, ((j > 0) && (j % 3 == 0)) ? 32'd1 : 32'd0);
      check("R4 pair irq_hi", {31'd0, irq_hi}, ((j > 0) && (j % 5 == 0)) ? 32'd1 : 32'd0);
      @(negedge clk);
    end

    // R9: wide mode
    wr(4, 0); wr(5, 32'h3);
    wr(0, 32'hFFFF_FFFE); wr(1, 7); wr(2, 1); wr(3, 8);
    wr(4, 2 << 22);
    for (int j = 0; j < 3; j++) begin
      rd(0, lo); rd(1, hi);
      check("R9 upper field ignored", lo ^ hi, 32'hFFFF_FFFE ^ 32'd7);
      @(negedge clk);
    end
    wr(4, 2 << 6);
    for (int j = 0; j < 7; j++) begin
      rd(0, lo); rd(1, hi);
      w = (j <= 3) ? (64'h7_FFFF_FFFE + 64'(j)) : 64'(j - 4);
      check("R9 wide lo", lo, w[31:0]);
      check("R9 wide hi", hi, w[63:32]);
      check("R9 wide irq_lo", {31'd0, irq_lo}, (j == 4) ? 32'd1 : 32'd0);
      check("R9 wide irq_hi", {31'd0, irq_hi}, 32'd0);
      @(negedge clk);
    end

    // R10: parked arrangements
    for (int m = 2; m < 4; m++) begin
      wr(4, 0); wr(5, (m << 2) | 3);
      wr(0, 10); wr(1, 20); wr(2, 0); wr(3, 0);
      wr(4, (2 << 22) | (2 << 6));
      for (int j = 0; j < 4; j++) begin
        rd(0, lo); rd(1, hi);
        check("R10 parked lo", lo, 32'd10);
        check("R10 parked hi", hi, 32'd20);
        check("R10 parked irq", {30'd0, irq_lo, irq_hi}, 32'd0);
        @(negedge clk);
      end
    end

    // R11: compare with wrapped targets
    st = 32'hFFFF_FFF8;
    wr(4, 0); wr(5, 32'h7); wr(2, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) wr(8 + i, 32'h1000 + i);
    wr(8 + 3, st + 32'd12);
    wr(8 + 6, st + 32'd2);
    wr(0, st);
    wr(4, 2 << 6);
    for (int j = 0; j < 16; j++) begin
      rd(0, v);
      check("R11 cnt", v, st + 32'(j));
      lo = st + 32'(j) - 32'd1;
      check("R11 irq_cmp", {31'd0, irq_cmp},
            ((j >= 1) && ((lo == 32'h4) || (lo == 32'hFFFF_FFFA))) ? 32'd1 : 32'd0);
      check("R8 period wrap irq", {31'd0, irq_lo}, (j == 8) ? 32'd1 : 32'd0);
      @(negedge clk);
    end
    wr(4, 0);
    rd(0, v);
    wr(8, v);
    for (int j = 0; j < 3; j++) begin
      check("R11 stopped quiet", {31'd0, irq_cmp}, 32'd0);
      @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule